// File: doc/BRIEF.md
# Physical Address Qualification Unit

This stage turns a virtual address into the physical address that the memory system will see, and it decides whether that access may go ahead. Two mapping sources are supported. In the first, a fixed window of the virtual space is identity-mapped into physical space for kernel code. In the second, the caller supplies a physical page number obtained from a translation lookup, and the stage joins it with the page offset. The page-number lookup and the data permission checks belong to other blocks.

Once the physical address is formed, the stage rejects any bit set above the implemented physical width. It then applies the uncached-region rule. Addresses in the top half of the physical space are tagged uncacheable and strictly ordered, and a field of their upper bits is cleared. A small internal-register region inside that half, and any instruction fetch that lands in uncached space, are refused. The result is registered, so each request that is marked valid produces one qualified response on the following cycle.

Top module: `pa_qual`

## Requirements
- R1: The outputs are registered. `valid_o` equals `valid_i` of the previous cycle. When `valid_i` is low, `paddr_o`, `uncached_o`, `strict_o` and `fault_o` keep their values. After reset all outputs are zero.
- R2: A virtual address whose bits 47:41 equal 7'h7E uses the superpage window. Its physical bits 39:0 come straight from the virtual address. Physical bits 43:40 all copy virtual bit 40, so they become ones when bit 40 is set and zeros otherwise.
- R3: A superpage access made while `kernel_i` is low gives fault code 1 (access violation).
- R4: Any other address maps to `{ppn_i, vaddr_i[12:0]}`, giving a page shift of 13. For an instruction fetch (`fetch_i` high), bits 1:0 of the result are cleared.
- R5: If the formed address has any bit set above bit 43, the fault code is 2 (machine check).
- R6: If physical bit 43 is set and bits 42:35 are not all ones, `uncached_o` and `strict_o` are both set and bits 42:35 of `paddr_o` are cleared.
- R7: If physical bit 43 is set and bits 42:35 are all ones (the internal-register region), the fault code is 3 (unimplemented).
- R8: An instruction fetch that would be uncached gives fault code 3.
- R9: Whenever the fault code is not 0, `paddr_o`, `uncached_o` and `strict_o` are zero. Fault code 0 means the access is accepted.
- R10: Fault priority runs from highest to lowest: access violation, then machine check, then the bit-43 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| vaddr_i | input | 64 | Virtual address |
| ppn_i | input | 32 | Physical page number from the translation lookup |
| fetch_i | input | 1 | Request is an instruction fetch |
| kernel_i | input | 1 | Request is made in kernel mode |
| valid_o | output | 1 | Response present |
| paddr_o | output | 44 | Qualified physical address |
| uncached_o | output | 1 | Access must bypass the caches |
| strict_o | output | 1 | Access must be strictly ordered |
| fault_o | output | 2 | 0 none, 1 access violation, 2 machine check, 3 unimplemented |

## Verification
The hardest cases to reach are those where several rules collide in a single request. One example is a superpage address with bit 40 set, which becomes uncached through sign extension and then meets either a user-mode check or a fetch check. Another is a page number that sets both bit 43 and a bit above the implemented width, so the priority order decides the result. Directed requests build each collision from page numbers and window addresses chosen for the purpose. Random requests then bias about half of the addresses into the superpage window and set the high page-number bits often, and a behavioural model checks every cycle, including idle cycles where the outputs must hold.

// File: rtl/pa_qual_pkg.sv
package pa_qual_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ACV   = 2'd1,
    FLT_MCHK  = 2'd2,
    FLT_UNIMP = 2'd3
  } fault_e;
endpackage

// File: rtl/pa_qual_map.sv
module pa_qual_map #(
  parameter int VA_W     = 64,
  parameter int PPN_W    = 32,
  parameter int PG_SHIFT = 13,
  parameter int PA_W     = 44,
  parameter int RAW_W    = 45,
  parameter int SP_HI    = 47,
  parameter int SP_LO    = 41,
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E,
  parameter int SX_BIT   = 40
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic             fetch_i,
  output logic             super_o,
  output logic [RAW_W-1:0] raw_o
);
  localparam int TLB_W = PPN_W + PG_SHIFT;

  logic [PA_W-1:0]  sp_pa;
  logic [TLB_W-1:0] tlb_pa;

  assign super_o = (vaddr_i[SP_HI:SP_LO] == SP_TAG);

  // identity window, upper bits follow the extension bit
  assign sp_pa = {{(PA_W-SX_BIT){vaddr_i[SX_BIT]}}, vaddr_i[SX_BIT-1:0]};

  always_comb begin
    tlb_pa = {ppn_i, vaddr_i[PG_SHIFT-1:0]};
    if (fetch_i) tlb_pa[1:0] = 2'b00;
  end

  assign raw_o = super_o ? RAW_W'(sp_pa) : RAW_W'(tlb_pa);
endmodule

// File: rtl/pa_qual_check.sv
module pa_qual_check
  import pa_qual_pkg::*;
#(
  parameter int PA_W   = 44,
  parameter int RAW_W  = 45,
  parameter int UC_BIT = 43,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35
) (
  input  logic [RAW_W-1:0] raw_i,
  input  logic             super_i,
  input  logic             fetch_i,
  input  logic             kernel_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic             uncached_o,
  output logic             strict_o,
  output fault_e           fault_o
);
  localparam int CLR_N = CLR_HI - CLR_LO + 1;
  localparam logic [PA_W-1:0] CLR_MASK =
    PA_W'(((64'd1 << CLR_N) - 64'd1) << CLR_LO);

  logic            over;
  logic [PA_W-1:0] pa0;
  logic            reg_space;
  logic            uc;

  generate
    if (RAW_W > PA_W) begin : g_over
      assign over = |raw_i[RAW_W-1:PA_W];
    end else begin : g_no_over
      assign over = 1'b0;
    end
  endgenerate

  assign pa0       = raw_i[PA_W-1:0];
  assign reg_space = pa0[UC_BIT] & (&pa0[CLR_HI:CLR_LO]);
  assign uc        = pa0[UC_BIT] & ~reg_space;

  always_comb begin
    if (super_i && !kernel_i)  fault_o = FLT_ACV;
    else if (over)             fault_o = FLT_MCHK;
    else if (reg_space)        fault_o = FLT_UNIMP;
    else if (uc && fetch_i)    fault_o = FLT_UNIMP;
    else                       fault_o = FLT_NONE;
  end

  always_comb begin
    paddr_o    = '0;
    uncached_o = 1'b0;
    strict_o   = 1'b0;
    if (fault_o == FLT_NONE) begin
      paddr_o    = uc ? (pa0 & ~CLR_MASK) : pa0;
      uncached_o = uc;
      strict_o   = uc;
    end
  end
endmodule

// File: rtl/pa_qual.sv
module pa_qual
  import pa_qual_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PPN_W    = 32,
  parameter int PG_SHIFT = 13,
  parameter int PA_W     = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic             fetch_i,
  input  logic             kernel_i,
  output logic             valid_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             uncached_o,
  output logic             strict_o,
  output logic [1:0]       fault_o
);
  localparam int TLB_W = PPN_W + PG_SHIFT;
  localparam int RAW_W = (TLB_W > PA_W) ? TLB_W : PA_W;

  logic             super_w;
  logic [RAW_W-1:0] raw_w;
  logic [PA_W-1:0]  pa_w;
  logic             uc_w, so_w;
  fault_e           flt_w;

  pa_qual_map #(
    .VA_W(VA_W), .PPN_W(PPN_W), .PG_SHIFT(PG_SHIFT),
    .PA_W(PA_W), .RAW_W(RAW_W)
  ) u_map (
    .vaddr_i (vaddr_i),
    .ppn_i   (ppn_i),
    .fetch_i (fetch_i),
    .super_o (super_w),
    .raw_o   (raw_w)
  );

  pa_qual_check #(
    .PA_W(PA_W), .RAW_W(RAW_W)
  ) u_chk (
    .raw_i      (raw_w),
    .super_i    (super_w),
    .fetch_i    (fetch_i),
    .kernel_i   (kernel_i),
    .paddr_o    (pa_w),
    .uncached_o (uc_w),
    .strict_o   (so_w),
    .fault_o    (flt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      paddr_o    <= '0;
      uncached_o <= 1'b0;
      strict_o   <= 1'b0;
      fault_o    <= FLT_NONE;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        paddr_o    <= pa_w;
        uncached_o <= uc_w;
        strict_o   <= so_w;
        fault_o    <= flt_w;
      end
    end
  end
endmodule

// File: rtl/pa_qual_sva.sv
module pa_qual_sva #(
  parameter int VA_W  = 64,
  parameter int PPN_W = 32,
  parameter int PA_W  = 44
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic [PPN_W-1:0] ppn_i,
  input logic             fetch_i,
  input logic             kernel_i,
  input logic             valid_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic             uncached_o,
  input logic             strict_o,
  input logic [1:0]       fault_o
);
  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(paddr_o) && $stable(fault_o) && $stable(uncached_o));

  assert_user_super_acv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) && $past(vaddr_i[47:41] == 7'h7E) && !$past(kernel_i)
    |-> fault_o == 2'd1);

  assert_uc_clears_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncached_o |-> paddr_o[42:35] == 8'h00 && paddr_o[43] && strict_o);

  assert_no_uc_fetch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(fetch_i) |-> !uncached_o);

  assert_fault_zeroes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o != 2'd0 |-> paddr_o == '0 && !uncached_o && !strict_o);
endmodule

bind pa_qual pa_qual_sva #(.VA_W(VA_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vaddr_i(vaddr_i),
  .ppn_i(ppn_i), .fetch_i(fetch_i), .kernel_i(kernel_i), .valid_o(valid_o),
  .paddr_o(paddr_o), .uncached_o(uncached_o), .strict_o(strict_o),
  .fault_o(fault_o)
);

// File: tb/sim_pa_qual.sv
module sim_pa_qual;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic [31:0] ppn_i = '0;
  logic        fetch_i = 1'b0;
  logic        kernel_i = 1'b0;
  logic        valid_o;
  logic [43:0] paddr_o;
  logic        uncached_o, strict_o;
  logic [1:0]  fault_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [43:0] e_pa = '0;
  logic        e_uc = 1'b0, e_so = 1'b0, e_v = 1'b0;
  logic [1:0]  e_flt = '0;

  pa_qual u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .vaddr_i(vaddr_i),
    .ppn_i(ppn_i), .fetch_i(fetch_i), .kernel_i(kernel_i), .valid_o(valid_o),
    .paddr_o(paddr_o), .uncached_o(uncached_o), .strict_o(strict_o),
    .fault_o(fault_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      summary();
    end
  end

  // behavioural reference: R2..R10
  function automatic void model(input logic [63:0] va, input logic [31:0] ppn,
                                input bit fe, input bit kn, output logic [43:0] pa,
                                output bit uc, output logic [1:0] flt);
    logic [63:0] p;
    bit sp;
    uc  = 0;
    flt = 0;
    sp  = (((va >> 41) & 64'h7F) == 64'h7E);
    if (sp) begin
      if (!kn) flt = 1;
      p = va & 64'hFFF_FFFF_FFFF;
      if (p[40]) p = p | 64'hF00_0000_0000;
      else       p = p & 64'hFF_FFFF_FFFF;
    end else begin
      p = ({32'd0, ppn} << 13) + (va & 64'h1FFF);
      if (fe) p = p & ~64'd3;
    end
    if (flt == 0 && (p >> 44) != 0) flt = 2;
    if (flt == 0 && p[43]) begin
      if (((p >> 35) & 64'hFF) == 64'hFF) flt = 3;
      else begin
        uc = 1;
        p = p & ~(64'hFF << 35);
        if (fe) flt = 3;
      end
    end
    if (flt != 0) begin
      p  = 0;
      uc = 0;
    end
    pa = p[43:0];
  endfunction

  task automatic compare(string tag);
    checks++;
    if (valid_o !== e_v || paddr_o !== e_pa || uncached_o !== e_uc ||
        strict_o !== e_so || fault_o !== e_flt) begin
      fails++;
      $display("FAIL %s: actual v=%0b pa=%h uc=%0b so=%0b f=%0d expected v=%0b pa=%h uc=%0b so=%0b f=%0d",
               tag, valid_o, paddr_o, uncached_o, strict_o, fault_o,
               e_v, e_pa, e_uc, e_so, e_flt);
    end
  endtask

  // called at a negedge; result checked at the following negedge
  task automatic step(bit v, logic [63:0] va, logic [31:0] ppn, bit fe, bit kn,
                      string tag);
    logic [43:0] pa;
    bit uc;
    logic [1:0] flt;
    valid_i = v; vaddr_i = va; ppn_i = ppn; fetch_i = fe; kernel_i = kn;
    if (v) begin
      model(va, ppn, fe, kn, pa, uc, flt);
      e_pa = pa; e_uc = uc; e_so = uc; e_flt = flt;
    end
    e_v = v;
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 idle after reset");

    step(1, 64'h0000_FC00_0000_1234, 32'h0,         0, 1, "R2 superpage low");
    step(1, 64'h0000_FD00_0000_5678, 32'h0,         0, 1, "R2 R6 superpage bit40 uncached");
    step(1, 64'h0000_FC00_0000_1234, 32'h0,         0, 0, "R3 superpage user acv");
    step(1, 64'h0000_FD00_0000_5678, 32'h0,         1, 1, "R8 superpage fetch uncached");
    step(1, 64'h0000_0000_0040_1ABF, 32'h0001_2345, 0, 0, "R4 mapped data");
    step(1, 64'h0000_0000_0040_1ABF, 32'h0001_2345, 1, 0, "R4 mapped fetch clears low bits");
    step(1, 64'h0000_0000_0000_0010, 32'h8000_0000, 0, 1, "R5 machine check");
    step(1, 64'h0000_0000_0000_0040, 32'h4000_0001, 0, 1, "R6 mapped uncached");
    step(1, 64'h0000_0000_0000_0040, 32'h7FC0_0000, 0, 1, "R7 register space");
    step(1, 64'h0000_0000_0000_0040, 32'h4000_0001, 1, 1, "R8 mapped fetch uncached");
    step(1, 64'h0000_0000_0000_0040, 32'hC000_0000, 0, 1, "R10 mchk over uncached");
    step(1, 64'h0000_FD00_0000_5678, 32'hFFFF_FFFF, 1, 0, "R10 acv first");
    step(0, 64'h0000_0000_0000_0000, 32'h0,         0, 0, "R1 hold idle");
    step(0, 64'h0000_FC00_0000_0000, 32'h8000_0000, 1, 0, "R1 hold ignores inputs");
    step(1, 64'h0000_FC00_0000_0000, 32'h0,         0, 1, "R9 clean after fault");

    for (int i = 0; i < 2000; i++) begin
      logic [63:0] va;
      logic [31:0] ppn;
      va  = {$urandom, $urandom};
      ppn = $urandom;
      if ($urandom_range(1, 0) == 1) va[47:41] = 7'h7E;
      if ($urandom_range(3, 0) == 0) ppn[29:22] = 8'hFF;
      step($urandom_range(3, 0) != 0, va, ppn, $urandom_range(1, 0) == 1,
           $urandom_range(3, 0) != 0, "R2 R4 R5 R6 R7 R8 R9 R10 random");
    end
    summary();
  end
endmodule